// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This peripheral guards a system against software that stops responding. Software loads a timeout value, enables a down-counter and must keep writing a fixed 16-bit key to a restart register before the counter runs out. If the count reaches zero, a sticky status flag is raised and up to three outputs (a reset request, an interrupt and an external signal) pulse high for a programmable number of bus cycles. Each output has its own enable bit.

The counter runs either on every bus clock cycle or once per rising edge of a slower external clock. The external clock is brought into the bus clock domain through two flops and an edge detector. All registers are 32 bits wide and sit on a simple two-phase peripheral bus (select, then enable). A write takes effect only in the access phase.

Top module: `wdog_top`

## Requirements
- R1: After reset, the reload register reads 0x03EF1480, the count register reads 0x03EF1480, the pulse length register reads 0xFF, and the control and status registers read 0. All three outputs are low.
- R2: The register offsets are: count 0x00 (read-only), reload 0x04, restart 0x08, control 0x0C, status 0x10, clear 0x14 and pulse length 0x18 (low 8 bits). A write to the count register is ignored. The restart and clear registers read as 0.
- R3: A write of exactly 0x00005AB9 to offset 0x08 loads the counter with the reload value at that clock edge. Any other data written there leaves the count unchanged.
- R4: Control bit 0 runs the counter. While this bit is 0, the count holds its value. With control bit 4 clear, the count decrements by one on every bus clock cycle.
- R5: With control bit 4 set, the count decrements once for each rising edge of `ext_clk`, after two synchronizing flops and an edge detector. While `ext_clk` does not toggle, the count holds.
- R6: When the count steps from 1 to 0, status bit 0 sets at that same edge. The count then stays at 0 until the next restart.
- R7: A write to offset 0x14 with bit 0 set clears status bit 0. A write there with bit 0 clear does nothing.
- R8: At a timeout, `rst_out`, `irq_out` and `ext_out` go high for (pulse length + 1) bus cycles. Each output pulses only if its enable bit was set when the timeout happened: control bit 1 for reset, bit 2 for interrupt, bit 3 for external.
- R9: Clearing control bits while a pulse is in progress does not shorten that pulse.
- R10: A write happens only when select, enable and write are all high. A setup-phase cycle (select without enable) changes no register.
- R11: A valid restart in the same cycle in which the count would step from 1 to 0 takes priority. No timeout occurs and status stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational from `paddr`) |
| ext_clk | input | 1 | Slow external count clock; its period must exceed two bus cycles |
| rst_out | output | 1 | Reset request pulse |
| irq_out | output | 1 | Interrupt pulse |
| ext_out | output | 1 | External signal pulse |

## Verification
The hardest case to reach is a restart that lands in exactly the cycle in which the count would reach zero (R11). The bench gets there by watching its own reference model's count. When the model shows a count of 1, the bench drives a full access-phase restart straight onto the bus, without a setup cycle, so the write meets the expiring edge. The second hard case is a control write that lands in the middle of a pulse (R9). The bench starts that write as soon as it sees the interrupt output rise. It then measures the length of the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] OFS_COUNT   = 8'h00;
  localparam logic [7:0] OFS_RELOAD  = 8'h04;
  localparam logic [7:0] OFS_RESTART = 8'h08;
  localparam logic [7:0] OFS_CTRL    = 8'h0C;
  localparam logic [7:0] OFS_STATUS  = 8'h10;
  localparam logic [7:0] OFS_CLEAR   = 8'h14;
  localparam logic [7:0] OFS_PLEN    = 8'h18;

  localparam logic [31:0] RESTART_KEY = 32'h0000_5AB9;

  // Control word; the first member is the MSB (bit 4).
  typedef struct packed {
    logic src_ext;  // bit4: 1 = external clock ticks
    logic ext_en;   // bit3
    logic irq_en;   // bit2
    logic rst_en;   // bit1
    logic run;      // bit0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Next value of the down-counter.
  function automatic logic [31:0] count_next(input logic [31:0] cur,
                                             input logic        restart,
                                             input logic        step,
                                             input logic [31:0] reload);
    if (restart)   return reload;
    else if (step) return cur - 32'd1;
    else           return cur;
  endfunction

  // A decrement that lands on zero and is not overridden by a restart.
  function automatic logic lands_on_zero(input logic [31:0] cur,
                                         input logic        step,
                                         input logic        restart);
    return step && !restart && (cur == 32'd1);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LEN_W       = 8,
  parameter logic [31:0] RELOAD_INIT = 32'h03EF_1480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output logic [DATA_W-1:0] reload,
  output ctrl_t             ctrl,
  output logic [LEN_W-1:0]  plen,
  output logic              status,
  output logic              restart_hit,
  output logic              clear_hit
);

  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CLEAR   = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_PLEN    = ADDR_W'(OFS_PLEN);

  logic wr_access;
  assign wr_access   = psel && penable && pwrite;
  assign restart_hit = wr_access && (paddr == A_RESTART) && (pwdata == DATA_W'(RESTART_KEY));
  assign clear_hit   = wr_access && (paddr == A_CLEAR) && pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= DATA_W'(RELOAD_INIT);
      ctrl   <= '0;
      plen   <= '1;
    end else if (wr_access) begin
      if (paddr == A_RELOAD) reload <= pwdata;
      if (paddr == A_CTRL)   ctrl   <= ctrl_t'(pwdata[CTRL_W-1:0]);
      if (paddr == A_PLEN)   plen   <= pwdata[LEN_W-1:0];
    end
  end

  // A timeout that happens in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= 1'b0;
    else if (expire)    status <= 1'b1;
    else if (clear_hit) status <= 1'b0;
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_COUNT:  prdata = count;
      A_RELOAD: prdata = reload;
      A_CTRL:   prdata = DATA_W'(ctrl);
      A_STATUS: prdata = DATA_W'(status);
      A_PLEN:   prdata = DATA_W'(plen);
      default:  prdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic use_ext,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= ext_clk;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  logic ext_rise;
  assign ext_rise = sync_q[SYNC_STAGES-1] && !last_q;
  assign tick     = use_ext ? ext_rise : 1'b1;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] CNT_INIT = 32'h03EF_1480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic step;
  assign step   = run && tick && (count != '0);
  assign expire = lands_on_zero(32'(count), step, restart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= CNT_W'(CNT_INIT);
    else        count <= CNT_W'(count_next(32'(count), restart, step, 32'(reload)));
  end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  input  logic [N_OUT-1:0] en_mask,
  output logic [N_OUT-1:0] outs,
  output logic             active
);

  logic [LEN_W-1:0] left_q;
  logic [N_OUT-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left_q <= '0;
      mask_q <= '0;
    end else if (fire) begin
      active <= 1'b1;
      left_q <= len;
      mask_q <= en_mask;
    end else if (active) begin
      if (left_q == '0) active <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  genvar i;
  generate
    for (i = 0; i < N_OUT; i++) begin : g_out
      assign outs[i] = active && mask_q[i];
    end
  endgenerate

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] RELOAD_INIT = 32'h03EF_1480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              ext_clk,
  output logic              rst_out,
  output logic              irq_out,
  output logic              ext_out
);

  localparam int unsigned N_OUT = 3;

  logic [DATA_W-1:0] count, reload;
  logic [LEN_W-1:0]  plen;
  ctrl_t             ctrl;
  logic              status, restart_hit, clear_hit, expire, tick, pulse_active;
  logic [N_OUT-1:0]  out_vec;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .count(count), .expire(expire),
    .reload(reload), .ctrl(ctrl), .plen(plen), .status(status),
    .restart_hit(restart_hit), .clear_hit(clear_hit)
  );

  wdog_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .use_ext(ctrl.src_ext), .tick(tick)
  );

  wdog_counter #(.CNT_W(DATA_W), .CNT_INIT(RELOAD_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick), .restart(restart_hit),
    .reload(reload), .count(count), .expire(expire)
  );

  wdog_pulse #(.LEN_W(LEN_W), .N_OUT(N_OUT)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .len(plen),
    .en_mask({ctrl.ext_en, ctrl.irq_en, ctrl.rst_en}),
    .outs(out_vec), .active(pulse_active)
  );

  assign rst_out = out_vec[0];
  assign irq_out = out_vec[1];
  assign ext_out = out_vec[2];

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] count,
  input logic [31:0] reload,
  input logic        run,
  input logic        use_ext,
  input logic        tick,
  input logic        restart_hit,
  input logic        clear_hit,
  input logic        expire,
  input logic        status,
  input logic        pulse_active,
  input logic        rst_out,
  input logic        irq_out,
  input logic        ext_out
);

  assert_restart_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |=> count == $past(reload));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart_hit) |=> $stable(count));

  assert_single_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && tick) |=> !(use_ext && tick));

  assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 32'd0 && !restart_hit) |=> count == 32'd0);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_hit && !expire) |=> !status);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pulse_active);

  assert_out_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out || irq_out || ext_out) |-> pulse_active);

  assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |-> !expire);

endmodule

bind wdog_top wdog_chk u_wdog_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .reload(reload), .run(ctrl.run),
  .use_ext(ctrl.src_ext), .tick(tick), .restart_hit(restart_hit), .clear_hit(clear_hit),
  .expire(expire), .status(status), .pulse_active(pulse_active),
  .rst_out(rst_out), .irq_out(irq_out), .ext_out(ext_out)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = 8'h00;
  logic [31:0] pwdata = 32'h0;
  logic        ext_clk = 1'b0;
  wire  [31:0] prdata;
  wire         rst_out, irq_out, ext_out;

  always #5 clk = ~clk;

  wdog_top i_wdog_top (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_clk(ext_clk),
    .rst_out(rst_out), .irq_out(irq_out), .ext_out(ext_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned m_cnt, m_reload, m_ctrl, m_plen;
  bit          m_status;
  int          m_left;    // -1 when no pulse
  int unsigned m_mask;
  bit          ext_hist[$];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_cnt;
      8'h04:   return m_reload;
      8'h0C:   return m_ctrl & 32'h1F;
      8'h10:   return {31'b0, m_status};
      8'h18:   return m_plen & 32'hFF;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 32'h03EF1480; m_reload = 32'h03EF1480; m_ctrl = 0; m_plen = 255;
      m_status = 0; m_left = -1; m_mask = 0;
      ext_hist = '{0, 0, 0};
    end else begin
      bit wr, go, ticked, step, hit;
      wr     = psel && penable && pwrite;
      go     = wr && paddr == 8'h08 && pwdata == 32'h5AB9;
      ticked = ((m_ctrl >> 4) & 1) ? (ext_hist[1] && !ext_hist[2]) : 1'b1;
      step   = (m_ctrl & 1) && ticked && m_cnt != 0;
      hit    = step && !go && m_cnt == 1;
      if (go) m_cnt = m_reload;
      else if (step) m_cnt = m_cnt - 1;
      if (hit) m_status = 1;
      else if (wr && paddr == 8'h14 && pwdata[0]) m_status = 0;
      if (hit) begin
        m_left = int'(m_plen);
        m_mask = (m_ctrl >> 1) & 7;
      end else if (m_left >= 0) m_left = m_left - 1;
      if (wr && paddr == 8'h04) m_reload = pwdata;
      if (wr && paddr == 8'h0C) m_ctrl = pwdata & 32'h1F;
      if (wr && paddr == 8'h18) m_plen = pwdata & 32'hFF;
      ext_hist.push_front(ext_clk);
      void'(ext_hist.pop_back());
    end
  end

  // Per-cycle comparison and pulse-width monitors
  int run_rst = 0, run_irq = 0, run_ext = 0;
  int last_rst = 0, last_irq = 0, last_ext = 0, tot_rst = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(prdata == m_read(paddr), "R2 read data vs model", prdata, m_read(paddr));
      chk(rst_out == (m_left >= 0 && m_mask[0]), "R8 rst_out vs model", 32'(rst_out), 32'(m_left >= 0 && m_mask[0]));
      chk(irq_out == (m_left >= 0 && m_mask[1]), "R8 irq_out vs model", 32'(irq_out), 32'(m_left >= 0 && m_mask[1]));
      chk(ext_out == (m_left >= 0 && m_mask[2]), "R8 ext_out vs model", 32'(ext_out), 32'(m_left >= 0 && m_mask[2]));
    end
    if (rst_out) begin run_rst++; tot_rst++; end else if (run_rst > 0) begin last_rst = run_rst; run_rst = 0; end
    if (irq_out) run_irq++; else if (run_irq > 0) begin last_irq = run_irq; run_irq = 0; end
    if (ext_out) run_ext++; else if (run_ext > 0) begin last_ext = run_ext; run_ext = 0; end
  end

  // External clock source: period of 6 bus cycles
  bit ext_run = 0;
  int ext_div = 0;
  always @(negedge clk) begin
    if (ext_run) begin
      ext_div++;
      if (ext_div == 3) begin ext_div = 0; ext_clk <= ~ext_clk; end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); #1 penable = 1;
    @(negedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic setup_only(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); #1 psel = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); #1 penable = 1;
    #2 chk(prdata === exp, tag, prdata, exp);
    @(negedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, R1..R11 run incomplete actual=%h expected=%h", 32'h0, 32'h1);
      summary();
    end
  end

  initial begin
    int guard;
    idle(3);
    #1 rst_n = 1;

    // R1 reset state
    chk({rst_out, irq_out, ext_out} == 3'b000, "R1 outputs low", 32'({rst_out, irq_out, ext_out}), 0);
    rd(8'h04, 32'h03EF1480, "R1 reload reset");
    rd(8'h00, 32'h03EF1480, "R1 count reset");
    rd(8'h18, 32'h000000FF, "R1 pulse length reset");
    rd(8'h0C, 32'h0, "R1 control reset");
    rd(8'h10, 32'h0, "R1 status reset");

    // R2 map details
    rd(8'h08, 32'h0, "R2 restart reads zero");
    rd(8'h14, 32'h0, "R2 clear reads zero");
    wr(8'h00, 32'h5);
    rd(8'h00, 32'h03EF1480, "R2 count is read-only");

    // R10 setup phase alone writes nothing
    setup_only(8'h18, 32'h3);
    rd(8'h18, 32'hFF, "R10 setup phase ignored");

    wr(8'h18, 32'h3);
    wr(8'h04, 32'd10);
    rd(8'h04, 32'd10, "R2 reload write");

    // R3 key
    wr(8'h08, 32'h5AB8);
    rd(8'h00, 32'h03EF1480, "R3 wrong key ignored");
    wr(8'h08, 32'h00015AB9);
    rd(8'h00, 32'h03EF1480, "R3 key with upper bits ignored");
    wr(8'h08, 32'h5AB9);
    rd(8'h00, 32'd10, "R3 key loads reload");

    // R4 frozen while disabled
    idle(5);
    rd(8'h00, 32'd10, "R4 count holds while disabled");

    // R4/R6/R8 bus-clock timeout, all outputs enabled
    wr(8'h0C, 32'h0F);
    idle(30);
    rd(8'h10, 32'h1, "R6 status set on timeout");
    rd(8'h00, 32'h0, "R6 count holds at zero");
    chk(last_rst == 4, "R8 rst pulse width", last_rst, 4);
    chk(last_irq == 4, "R8 irq pulse width", last_irq, 4);
    chk(last_ext == 4, "R8 ext pulse width", last_ext, 4);

    // R7 clear
    wr(8'h14, 32'h0);
    rd(8'h10, 32'h1, "R7 clear with bit0=0 ignored");
    wr(8'h14, 32'h1);
    rd(8'h10, 32'h0, "R7 clear with bit0=1");

    // R8/R9 interrupt only, control cleared mid-pulse
    last_irq = 0;
    begin
      int rst_before;
      rst_before = tot_rst;
      wr(8'h0C, 32'h05);
      wr(8'h08, 32'h5AB9);
      guard = 0;
      while (!irq_out && guard < 100) begin @(negedge clk); guard++; end
      wr(8'h0C, 32'h0);
      idle(10);
      chk(last_irq == 4, "R9 pulse not shortened by control write", last_irq, 4);
      chk(tot_rst == rst_before, "R8 disabled reset output stays low", tot_rst, rst_before);
    end
    wr(8'h14, 32'h1);

    // R11 restart on the expiring cycle
    wr(8'h04, 32'd5);
    wr(8'h0C, 32'h01);
    wr(8'h08, 32'h5AB9);
    guard = 0;
    while (m_cnt != 1 && guard < 100) begin @(negedge clk); guard++; end
    #1 psel = 1; penable = 1; pwrite = 1; paddr = 8'h08; pwdata = 32'h5AB9;
    @(negedge clk); #1 psel = 0; penable = 0; pwrite = 0;
    rd(8'h10, 32'h0, "R11 restart beats timeout");
    wr(8'h0C, 32'h0);

    // R5 external clock
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h15);
    wr(8'h08, 32'h5AB9);
    idle(10);
    rd(8'h00, 32'd3, "R5 holds without external edges");
    ext_run = 1;
    idle(40);
    rd(8'h10, 32'h1, "R5 external edges reach timeout");
    ext_run = 0;
    wr(8'h0C, 32'h0);
    idle(4);

    done = 1;
    summary();
  end

endmodule